// File: doc/BRIEF.md
# Field-encoded microprogram sequencer

This block is the control unit of a processor built around a microprogram. A microaddress register selects one word of an internal read-only control store. That word is captured in a micro-instruction register. Its packed fields are expanded into one-hot strobes that steer the datapath: one bus driver, one bus receiver, one memory-side or operand latch, and one ALU operation. The block also raises a memory read request and a wait-for-memory flag. The datapath itself lies outside this block.

Each micro-instruction names its own successor. The successor is either an explicit address held in the word, or a starting address formed from the macro-instruction opcode. The word may then widen that choice by ORing in the operand addressing-mode bits, the indirect-source flag, or both. This gives multi-way dispatch with no adder. A word that carries the wait flag stalls the sequencer until memory reports completion. The control-store image is an elaboration parameter, so each integration supplies its own microprogram.

Top module: `mseq_core`

## Requirements
- R1: Bus-source field (word bits [25:23]) drives `src_oh` one-hot. Codes 1,2,3,4,5 set bits 0..4 (PC out, MDR out, Z out, source-register out, destination-register out). Codes 0, 6 and 7 set no bit.
- R2: Bus-destination field (bits [22:20]) drives `dst_oh`. Codes 1..5 set bits 0..4 (PC in, IR in, Z in, source-register in, destination-register in). Codes 0, 6 and 7 set no bit.
- R3: Latch field (bits [19:17]) drives `aux_oh`. Codes 1..4 set bits 0..3 (MAR in, MDR in, TEMP in, Y in). Codes 0 and 5..7 set no bit.
- R4: ALU field (bits [16:13]) sets exactly bit n of `alu_oh` for code n. Code 0 is ADD, 1 is SUB and 15 is XOR.
- R5: Word bit 12 appears on `mem_read` and bit 11 on `mem_wait`. Bits 10, 9 and 8 are OR-indirect, OR-mode and select. Bits [7:0] are the explicit next address.
- R6: When select, OR-mode and OR-indirect are all 0, the next microaddress is the next-address field.
- R7: When select is 1, the base address is the opcode shifted left by OP_SHIFT (3 by default) and zero-extended.
- R8: When OR-mode is 1, `ir_mode` is ORed into microaddress bits [MODE_W-1:0].
- R9: When OR-indirect is 1, `ind_src` is ORed into microaddress bit MODE_W (bit 2 by default).
- R10: While the current word has the wait bit set and `mem_done` is low, `uaddr` and all decoded outputs hold. A word without the wait bit advances whatever `mem_done` is.
- R11: An active-low `rst_n` (asynchronous) forces `uaddr` to 0 with word 0 in the micro-instruction register. Its fields are decoded at once.
- R12: One micro-instruction executes per clock. `uaddr` always equals the address of the word whose fields drive the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_opcode | input | OP_W (4) | Opcode field of the macro-instruction |
| ir_mode | input | MODE_W (2) | Addressing-mode bits of the macro-instruction |
| ind_src | input | 1 | Indirect-source status flag |
| mem_done | input | 1 | Memory-complete status |
| uaddr | output | 8 | Address of the executing micro-instruction |
| src_oh | output | 5 | One-hot bus-source strobes |
| dst_oh | output | 5 | One-hot bus-destination strobes |
| aux_oh | output | 4 | One-hot MAR/MDR/TEMP/Y latch strobes |
| alu_oh | output | 16 | One-hot ALU operation |
| mem_read | output | 1 | Memory read request |
| mem_wait | output | 1 | Current word waits for memory |

## Verification
The wait-for-memory stall and the OR-based address modification can fall in the same cycle. The bench's microprogram holds a word that sets both the wait bit and OR-indirect. The bench keeps `mem_done` low across that word while `ind_src` is high. It then judges that the modified successor address does not appear, and that every strobe stays frozen, until completion arrives. After that, the bench expects the address with bit 2 set. A second overlap sets `mem_done` low on words without the wait bit, and the bench expects normal advance there.

// File: rtl/mseq_pkg.sv
`timescale 1ns/1ps
package mseq_pkg;

   localparam int SRC_W  = 3;
   localparam int DST_W  = 3;
   localparam int AUX_W  = 3;
   localparam int ALU_W  = 4;
   localparam int UA_W   = 8;
   localparam int N_SRC  = 5;
   localparam int N_DST  = 5;
   localparam int N_AUX  = 4;
   localparam int N_ALU  = 1 << ALU_W;
   localparam int UDEPTH = 1 << UA_W;

   // micro-instruction layout, most significant field first
   typedef struct packed {
      logic [SRC_W-1:0] src;
      logic [DST_W-1:0] dst;
      logic [AUX_W-1:0] aux;
      logic [ALU_W-1:0] alu;
      logic             rd;
      logic             wt;
      logic             or_ind;
      logic             or_mode;
      logic             sel;
      logic [UA_W-1:0]  nxt;
   } uword_t;

   localparam int UW = $bits(uword_t);

   typedef logic [UDEPTH-1:0][UW-1:0] uimage_t;

   function automatic uword_t mk_word(
      input logic [SRC_W-1:0] s,
      input logic [DST_W-1:0] d,
      input logic [AUX_W-1:0] a,
      input logic [ALU_W-1:0] f,
      input logic             rd,
      input logic             wt,
      input logic             oi,
      input logic             om,
      input logic             sl,
      input logic [UA_W-1:0]  nx);
      uword_t w;
      w.src     = s;
      w.dst     = d;
      w.aux     = a;
      w.alu     = f;
      w.rd      = rd;
      w.wt      = wt;
      w.or_ind  = oi;
      w.or_mode = om;
      w.sel     = sl;
      w.nxt     = nx;
      return w;
   endfunction

   // small fetch plus register-add routine used when no image is supplied
   function automatic uimage_t default_image();
      uimage_t img;
      img = '0;
      img[0] = mk_word(3'd1, 3'd3, 3'd1, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01);
      img[1] = mk_word(3'd3, 3'd1, 3'd0, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h02);
      img[2] = mk_word(3'd2, 3'd2, 3'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
      for (int m = 0; m < 4; m++)
         img[8 + m] = mk_word(3'd4, 3'd0, 3'd4, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h40);
      img[8'h40] = mk_word(3'd5, 3'd3, 3'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h41);
      img[8'h41] = mk_word(3'd3, 3'd5, 3'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
      return img;
   endfunction

endpackage

// File: rtl/mseq_onehot_dec.sv
`timescale 1ns/1ps
module mseq_onehot_dec #(
   parameter int CODE_W = 3,
   parameter int N_OUT  = 5,
   parameter int FIRST  = 1
)(
   input  logic [CODE_W-1:0] code_i,
   output logic [N_OUT-1:0]  oh_o
);

   localparam int N_CODES = 1 << CODE_W;

   generate
      if (FIRST + N_OUT > N_CODES) begin : g_bad_range
         $error("mseq_onehot_dec: FIRST + N_OUT exceeds code space");
      end
      if (FIRST < 0) begin : g_bad_first
         $error("mseq_onehot_dec: FIRST must not be negative");
      end
   endgenerate

   // code FIRST+i raises bit i; codes outside that window raise nothing
   for (genvar i = 0; i < N_OUT; i++) begin : g_bit
      assign oh_o[i] = (code_i == CODE_W'(i + FIRST));
   end

endmodule

// File: rtl/mseq_next_addr.sv
`timescale 1ns/1ps
module mseq_next_addr
   import mseq_pkg::*;
#(
   parameter int OP_W     = 4,
   parameter int MODE_W   = 2,
   parameter int OP_SHIFT = 3
)(
   input  logic              sel_i,
   input  logic              or_mode_i,
   input  logic              or_ind_i,
   input  logic [UA_W-1:0]   nxt_i,
   input  logic [OP_W-1:0]   opcode_i,
   input  logic [MODE_W-1:0] mode_i,
   input  logic              ind_i,
   output logic [UA_W-1:0]   next_o
);

   generate
      if (OP_W + OP_SHIFT > UA_W) begin : g_bad_op
         $error("mseq_next_addr: opcode dispatch does not fit the microaddress");
      end
      if (MODE_W + 1 > OP_SHIFT) begin : g_bad_mode
         $error("mseq_next_addr: mode and indirect bits overlap the opcode");
      end
   endgenerate

   logic [UA_W-1:0] start_addr;
   logic [UA_W-1:0] base_addr;
   logic [UA_W-1:0] mode_mask;
   logic [UA_W-1:0] ind_mask;

   // dispatch base: opcode scaled so each opcode owns 2**OP_SHIFT words
   assign start_addr = UA_W'(opcode_i) << OP_SHIFT;
   assign base_addr  = sel_i ? start_addr : nxt_i;

   // branching by OR: low bits pick one of several neighbouring words
   assign mode_mask  = or_mode_i ? UA_W'(mode_i) : '0;
   assign ind_mask   = or_ind_i ? (UA_W'(ind_i) << MODE_W) : '0;

   assign next_o = base_addr | mode_mask | ind_mask;

endmodule

// File: rtl/mseq_store.sv
`timescale 1ns/1ps
module mseq_store
   import mseq_pkg::*;
#(
   parameter uimage_t IMAGE = default_image()
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mem_done,
   input  logic [UA_W-1:0] next_addr,
   output uword_t          uir,
   output logic [UA_W-1:0] uar
);

   uword_t          uir_q;
   logic [UA_W-1:0] uar_q;
   uword_t          rom_word;
   logic            advance;

   // read-only store indexed by the address about to be taken
   assign rom_word = uword_t'(IMAGE[next_addr]);

   // hold while the executing word waits on memory
   assign advance = !(uir_q.wt && !mem_done);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         uar_q <= '0;
         uir_q <= uword_t'(IMAGE[0]);
      end else if (advance) begin
         uar_q <= next_addr;
         uir_q <= rom_word;
      end
   end

   assign uir = uir_q;
   assign uar = uar_q;

endmodule

// File: rtl/mseq_core.sv
`timescale 1ns/1ps
module mseq_core
   import mseq_pkg::*;
#(
   parameter int      OP_W     = 4,
   parameter int      MODE_W   = 2,
   parameter int      OP_SHIFT = 3,
   parameter uimage_t UCODE    = default_image()
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OP_W-1:0]   ir_opcode,
   input  logic [MODE_W-1:0] ir_mode,
   input  logic              ind_src,
   input  logic              mem_done,
   output logic [UA_W-1:0]   uaddr,
   output logic [N_SRC-1:0]  src_oh,
   output logic [N_DST-1:0]  dst_oh,
   output logic [N_AUX-1:0]  aux_oh,
   output logic [N_ALU-1:0]  alu_oh,
   output logic              mem_read,
   output logic              mem_wait
);

   generate
      if (OP_W < 1 || MODE_W < 1) begin : g_bad_width
         $error("mseq_core: opcode and mode widths must be positive");
      end
   endgenerate

   uword_t          uir;
   logic [UA_W-1:0] next_addr;

   mseq_next_addr #(
      .OP_W     (OP_W),
      .MODE_W   (MODE_W),
      .OP_SHIFT (OP_SHIFT)
   ) u_next (
      .sel_i     (uir.sel),
      .or_mode_i (uir.or_mode),
      .or_ind_i  (uir.or_ind),
      .nxt_i     (uir.nxt),
      .opcode_i  (ir_opcode),
      .mode_i    (ir_mode),
      .ind_i     (ind_src),
      .next_o    (next_addr)
   );

   mseq_store #(
      .IMAGE (UCODE)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_done  (mem_done),
      .next_addr (next_addr),
      .uir       (uir),
      .uar       (uaddr)
   );

   mseq_onehot_dec #(.CODE_W(SRC_W), .N_OUT(N_SRC), .FIRST(1)) u_dec_src (
      .code_i (uir.src),
      .oh_o   (src_oh)
   );

   mseq_onehot_dec #(.CODE_W(DST_W), .N_OUT(N_DST), .FIRST(1)) u_dec_dst (
      .code_i (uir.dst),
      .oh_o   (dst_oh)
   );

   mseq_onehot_dec #(.CODE_W(AUX_W), .N_OUT(N_AUX), .FIRST(1)) u_dec_aux (
      .code_i (uir.aux),
      .oh_o   (aux_oh)
   );

   mseq_onehot_dec #(.CODE_W(ALU_W), .N_OUT(N_ALU), .FIRST(0)) u_dec_alu (
      .code_i (uir.alu),
      .oh_o   (alu_oh)
   );

   assign mem_read = uir.rd;
   assign mem_wait = uir.wt;

   // ---------------- assertions ----------------
   logic stall;
   assign stall = uir.wt && !mem_done;

   p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> ($stable(uaddr) && $stable(src_oh) && $stable(dst_oh)
                 && $stable(aux_oh) && $stable(alu_oh)))
      else $error("stall did not freeze the sequencer");

   p_plain_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && !uir.sel && !uir.or_mode && !uir.or_ind) |=> (uaddr == $past(uir.nxt)))
      else $error("explicit next address not taken");

   p_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && uir.sel && !uir.or_mode && !uir.or_ind)
      |=> (uaddr == (UA_W'($past(ir_opcode)) << OP_SHIFT)))
      else $error("opcode dispatch address wrong");

   p_ormode_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && uir.or_mode) |=> ((uaddr[MODE_W-1:0] & $past(ir_mode)) == $past(ir_mode)))
      else $error("mode bits not merged into next address");

   p_orind_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && uir.or_ind && ind_src) |=> uaddr[MODE_W])
      else $error("indirect flag not merged into next address");

endmodule

// File: tb/mseq_core_tb_top.sv
`timescale 1ns/1ps
module mseq_core_tb_top;

   // word layout per R1..R5: src[25:23] dst[22:20] aux[19:17] alu[16:13]
   // read[12] wait[11] or_ind[10] or_mode[9] sel[8] next[7:0]
   function automatic logic [25:0] mw(
      input logic [2:0] s, input logic [2:0] d, input logic [2:0] a,
      input logic [3:0] f, input logic rd, input logic wt, input logic oi,
      input logic om, input logic sl, input logic [7:0] nx);
      return {s, d, a, f, rd, wt, oi, om, sl, nx};
   endfunction

   function automatic logic [255:0][25:0] build_img();
      logic [255:0][25:0] m;
      m = '0;
      m[8'h00] = mw(3'd1, 3'd3, 3'd1, 4'd0,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01);
      m[8'h01] = mw(3'd3, 3'd1, 3'd0, 4'd0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h02);
      m[8'h02] = mw(3'd2, 3'd2, 3'd0, 4'd0,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
      m[8'h08] = mw(3'd4, 3'd0, 3'd4, 4'd0,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h30);
      m[8'h09] = mw(3'd4, 3'd0, 3'd1, 4'd0,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h50);
      m[8'h50] = mw(3'd2, 3'd0, 3'd4, 4'd0,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h30);
      m[8'h30] = mw(3'd5, 3'd3, 3'd0, 4'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h31);
      m[8'h34] = mw(3'd5, 3'd3, 3'd0, 4'd1,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h31);
      m[8'h31] = mw(3'd3, 3'd5, 3'd2, 4'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
      m[8'h10] = mw(3'd5, 3'd3, 3'd3, 4'd15, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h31);
      m[8'h13] = mw(3'd4, 3'd3, 3'd0, 4'd15, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h31);
      m[8'h18] = mw(3'd6, 3'd7, 3'd5, 4'd2,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
      return m;
   endfunction

   localparam logic [255:0][25:0] IMG = build_img();

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  ir_opcode = '0;
   logic [1:0]  ir_mode = '0;
   logic        ind_src = 1'b0;
   logic        mem_done = 1'b0;
   logic [7:0]  uaddr;
   logic [4:0]  src_oh;
   logic [4:0]  dst_oh;
   logic [3:0]  aux_oh;
   logic [15:0] alu_oh;
   logic        mem_read;
   logic        mem_wait;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #2 clk = ~clk;

   mseq_core #(.UCODE(IMG)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ir_opcode (ir_opcode),
      .ir_mode   (ir_mode),
      .ind_src   (ind_src),
      .mem_done  (mem_done),
      .uaddr     (uaddr),
      .src_oh    (src_oh),
      .dst_oh    (dst_oh),
      .aux_oh    (aux_oh),
      .alu_oh    (alu_oh),
      .mem_read  (mem_read),
      .mem_wait  (mem_wait)
   );

   function automatic logic [31:0] exp_oh(input int code, input int first, input int n);
      if (code >= first && code < first + n) return 32'd1 << (code - first);
      return 32'd0;
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic check_state(input logic [7:0] ea, input string tag);
      logic [25:0] w;
      logic [31:0] e;
      w = IMG[ea];
      chk(uaddr == ea, tag, "uaddr", 32'(uaddr), 32'(ea));
      e = exp_oh(int'(w[25:23]), 1, 5);
      chk(32'(src_oh) == e, "R1", "src_oh", 32'(src_oh), e);
      e = exp_oh(int'(w[22:20]), 1, 5);
      chk(32'(dst_oh) == e, "R2", "dst_oh", 32'(dst_oh), e);
      e = exp_oh(int'(w[19:17]), 1, 4);
      chk(32'(aux_oh) == e, "R3", "aux_oh", 32'(aux_oh), e);
      e = exp_oh(int'(w[16:13]), 0, 16);
      chk(32'(alu_oh) == e, "R4", "alu_oh", 32'(alu_oh), e);
      chk({mem_read, mem_wait} == w[12:11], "R5", "read/wait",
          32'({mem_read, mem_wait}), 32'(w[12:11]));
   endtask

   // monitor: compare the state reached after each edge against the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (exp_q.size() > 0) begin
            logic [7:0] ea;
            string      t;
            ea = exp_q.pop_front();
            t  = tag_q.pop_front();
            check_state(ea, t);
         end
      end
   end

   // driver: set the inputs for the coming edge and push the expected result
   task automatic step(input logic [7:0] ea, input string tag, input logic done);
      mem_done = done;
      exp_q.push_back(ea);
      tag_q.push_back(tag);
      @(negedge clk);
      #1;
   endtask

   task automatic set_ir(input logic [3:0] op, input logic [1:0] md, input logic ind);
      ir_opcode = op;
      ir_mode   = md;
      ind_src   = ind;
   endtask

   task automatic fetch_prefix();
      step(8'h01, "R12", 1'b0);   // word 0 has no wait bit: done low is ignored (R10)
      step(8'h02, "R6", 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check_state(8'h00, "R11");
      rst_n = 1'b1;

      // ADD, register mode, indirect clear: R7 dispatch, R9 with flag low
      set_ir(4'd1, 2'd0, 1'b0);
      fetch_prefix();
      step(8'h08, "R7", 1'b0);
      step(8'h30, "R9", 1'b0);
      step(8'h31, "R6", 1'b0);
      step(8'h00, "R6", 1'b0);

      // ADD with memory stall on the wait word, indirect set
      set_ir(4'd1, 2'd0, 1'b1);
      step(8'h01, "R6", 1'b0);
      step(8'h01, "R10", 1'b0);
      step(8'h01, "R10", 1'b0);
      step(8'h02, "R10", 1'b1);
      step(8'h08, "R7", 1'b0);
      step(8'h34, "R9", 1'b0);
      step(8'h31, "R6", 1'b0);
      step(8'h00, "R6", 1'b0);

      // mode 1: stall on a word that also ORs in the indirect flag
      set_ir(4'd1, 2'd1, 1'b1);
      fetch_prefix();
      step(8'h09, "R8", 1'b0);
      step(8'h50, "R6", 1'b0);
      step(8'h50, "R10", 1'b0);
      step(8'h34, "R9", 1'b1);
      step(8'h31, "R6", 1'b0);
      step(8'h00, "R6", 1'b0);

      // XOR opcode, mode 0 then mode 3
      set_ir(4'd2, 2'd0, 1'b0);
      fetch_prefix();
      step(8'h10, "R7", 1'b0);
      step(8'h31, "R6", 1'b0);
      step(8'h00, "R6", 1'b0);
      set_ir(4'd2, 2'd3, 1'b0);
      fetch_prefix();
      step(8'h13, "R8", 1'b0);
      step(8'h31, "R6", 1'b0);
      step(8'h00, "R6", 1'b0);

      // opcode 3: word with unused field codes decodes to no strobe (R1..R3)
      set_ir(4'd3, 2'd0, 1'b0);
      fetch_prefix();
      step(8'h18, "R7", 1'b0);
      step(8'h00, "R6", 1'b0);

      // reset in mid routine (R11), then a clean run
      set_ir(4'd1, 2'd0, 1'b0);
      fetch_prefix();
      step(8'h08, "R7", 1'b0);
      step(8'h30, "R9", 1'b0);
      rst_n = 1'b0;
      #1;
      check_state(8'h00, "R11");
      @(negedge clk);
      #1;
      check_state(8'h00, "R11");
      rst_n = 1'b1;
      fetch_prefix();
      step(8'h08, "R7", 1'b0);
      step(8'h30, "R9", 1'b0);
      step(8'h31, "R6", 1'b0);
      step(8'h00, "R6", 1'b0);

      @(negedge clk);
      @(negedge clk);
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule